// File: doc/BRIEF.md
# I2C Bus Error and Arbitration Monitor

This block sits beside the byte shift engine of an I2C controller. It watches the SCL and SDA wires, the level the controller itself drives onto SDA, and a few phase indications from the shift engine. From these it finds three faults:

- a Start or Stop condition that appears in the middle of a byte,
- a missing acknowledge,
- a lost arbitration.

Each fault sets its own sticky flag. The bus and acknowledge faults also set the shared event flag. On lost arbitration the block sends a one-cycle request that drops the controller back to slave mode. Whenever any fault flag is set, the block tells the clock-stretch logic to let SCL go.

Software clears the flags with a status read followed later by a control write. A missing acknowledge also freezes the transfer until software asks for a new Start or a Stop. Freeing a stuck SDA line is left to software.

Top module: `i2c_bus_err_mon`

## Requirements
- R1: `scl_i` and `sda_i` pass through a two-flop synchroniser that resets to 1. A Start is a 1-to-0 change of synchronised SDA while synchronised SCL is 1 in both the current and the previous sample. A Stop is a 0-to-1 change of SDA under the same SCL condition. SDA changes while SCL is 0 are not conditions.
- R2: A Start or Stop seen while `byte_active_i` is 1 sets `berr_o` and `evf_o`. The same condition with `byte_active_i` at 0 sets neither flag.
- R3: A rising synchronised SCL edge while `ack_slot_i` is 1 and synchronised SDA is 1 (no acknowledge) sets `af_o` and `evf_o`. SDA at 0 in that slot sets nothing.
- R4: `af_hold_o` goes to 1 together with an acknowledge failure. It returns to 0 only on `start_req_i` or `stop_req_i`, not on a flag clear.
- R5: A rising synchronised SCL edge with `master_i`, `data_bit_i` and `sda_drv_i` all at 1 and synchronised SDA at 0 sets `arlo_o`. It also gives exactly one cycle of `to_slave_o`, and leaves `evf_o` unchanged.
- R6: `irq_o` is 1 exactly when `ite_i` is 1 and either `evf_o` or `arlo_o` is 1.
- R7: `hold_release_o` is 1 whenever any of `berr_o`, `af_o` or `arlo_o` is 1, and 0 otherwise.
- R8: The flags `berr_o`, `af_o`, `arlo_o` and `evf_o` stay set until a `cr_write_i` pulse arrives after a `sr_read_i` pulse. A `cr_write_i` with no read before it clears nothing. A new error set in the clearing cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL wire level |
| sda_i | input | 1 | Raw SDA wire level |
| sda_drv_i | input | 1 | Level the controller drives on SDA (1 = released) |
| master_i | input | 1 | Controller is in master mode |
| byte_active_i | input | 1 | A byte transfer is in progress |
| data_bit_i | input | 1 | Current bit is an address or data bit |
| ack_slot_i | input | 1 | Current bit is the acknowledge slot to be received |
| ite_i | input | 1 | Interrupt enable |
| sr_read_i | input | 1 | Status read strobe |
| cr_write_i | input | 1 | Control write strobe |
| start_req_i | input | 1 | Software Start request |
| stop_req_i | input | 1 | Software Stop request |
| berr_o | output | 1 | Sticky bus error flag |
| af_o | output | 1 | Sticky acknowledge failure flag |
| arlo_o | output | 1 | Sticky arbitration lost flag |
| evf_o | output | 1 | Sticky shared event flag |
| irq_o | output | 1 | Interrupt request |
| hold_release_o | output | 1 | Forces the SCL stretch to release |
| af_hold_o | output | 1 | Transfer frozen after acknowledge failure |
| to_slave_o | output | 1 | One-cycle request to drop to slave mode |

## Verification
The bench aims at the cases that tell the error classes apart.

- **SDA moving while SCL is low.** A detector that ignores SCL would raise a false bus error.
- **Start or Stop outside a byte.** A monitor that does not gate on the byte phase would flag it.
- **Arbitration loss.** A design that also set the event flag, or that forgot the slave-mode pulse, would show the wrong `evf_o` or count no pulse.
- **The two-step clear.** A lone control write must leave the flags in place.
- **The acknowledge freeze.** It must outlive a flag clear and end only on a Start or Stop request.

Randomised runs mix these events with random enables and line levels.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } bus_cond_t;

  typedef struct packed {
    logic berr;
    logic af;
    logic arlo;
  } err_vec_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2   // must be >= 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  localparam int unsigned PIPE_W = STAGES * WIDTH;

  logic [PIPE_W-1:0] pipe_q;
  logic [WIDTH-1:0]  prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
      prev_q <= '1;
    end else begin
      pipe_q <= {pipe_q[PIPE_W-WIDTH-1:0], raw_i};
      prev_q <= pipe_q[PIPE_W-1 -: WIDTH];
    end
  end

  assign sync_o = pipe_q[PIPE_W-1 -: WIDTH];
  assign prev_o = prev_q;
endmodule

// File: rtl/i2c_mon_cond.sv
module i2c_mon_cond
  import i2c_mon_pkg::*;
(
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic [NUM_LINES-1:0] prev_i,
  output bus_cond_t            cond_o
);
  logic scl_s, scl_p, sda_s, sda_p, scl_steady_hi;

  assign scl_s = sync_i[LINE_SCL];
  assign scl_p = prev_i[LINE_SCL];
  assign sda_s = sync_i[LINE_SDA];
  assign sda_p = prev_i[LINE_SDA];
  assign scl_steady_hi = scl_s & scl_p;

  always_comb begin
    cond_o.start    = scl_steady_hi &  sda_p & ~sda_s;
    cond_o.stop     = scl_steady_hi & ~sda_p &  sda_s;
    cond_o.scl_rise = scl_s & ~scl_p;
  end
endmodule

// File: rtl/i2c_mon_flags.sv
module i2c_mon_flags
  import i2c_mon_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  err_vec_t set_i,
  input  logic     evf_set_i,
  input  logic     sr_read_i,
  input  logic     cr_write_i,
  input  logic     start_req_i,
  input  logic     stop_req_i,
  output err_vec_t flags_o,
  output logic     evf_o,
  output logic     af_hold_o
);
  err_vec_t flags_q;
  logic     evf_q, armed_q, af_hold_q, clr;

  assign clr = cr_write_i & armed_q;

  // read arms, the next control write consumes the arm
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         armed_q <= 1'b0;
    else if (cr_write_i) armed_q <= 1'b0;
    else if (sr_read_i)  armed_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      evf_q   <= 1'b0;
    end else if (clr) begin
      flags_q <= set_i;
      evf_q   <= evf_set_i;
    end else begin
      flags_q <= flags_q | set_i;
      evf_q   <= evf_q | evf_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        af_hold_q <= 1'b0;
    else if (set_i.af)                  af_hold_q <= 1'b1;
    else if (start_req_i | stop_req_i)  af_hold_q <= 1'b0;
  end

  assign flags_o   = flags_q;
  assign evf_o     = evf_q;
  assign af_hold_o = af_hold_q;

  a_r8_berr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.berr && !cr_write_i |=> flags_q.berr);
  a_r8_af_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_q.af && !cr_write_i |=> flags_q.af);
  a_r8_clear_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(evf_q) |-> $past(cr_write_i));
  a_r4_hold_until_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    af_hold_q && !start_req_i && !stop_req_i |=> af_hold_q);
  a_r5_evf_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evf_q) |-> $past(evf_set_i));
endmodule

// File: rtl/i2c_bus_err_mon.sv
module i2c_bus_err_mon
  import i2c_mon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sda_drv_i,
  input  logic master_i,
  input  logic byte_active_i,
  input  logic data_bit_i,
  input  logic ack_slot_i,
  input  logic ite_i,
  input  logic sr_read_i,
  input  logic cr_write_i,
  input  logic start_req_i,
  input  logic stop_req_i,
  output logic berr_o,
  output logic af_o,
  output logic arlo_o,
  output logic evf_o,
  output logic irq_o,
  output logic hold_release_o,
  output logic af_hold_o,
  output logic to_slave_o
);
  logic [NUM_LINES-1:0] raw, line_s, line_p;
  bus_cond_t cond;
  err_vec_t  set, flags;
  logic      sda_s, evf_set, evf, to_slave_q;

  assign raw[LINE_SCL] = scl_i;
  assign raw[LINE_SDA] = sda_i;

  i2c_mon_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .raw_i(raw), .sync_o(line_s), .prev_o(line_p)
  );

  i2c_mon_cond u_cond (.sync_i(line_s), .prev_i(line_p), .cond_o(cond));

  assign sda_s = line_s[LINE_SDA];

  always_comb begin
    set.berr = byte_active_i & (cond.start | cond.stop);
    set.af   = cond.scl_rise & ack_slot_i & sda_s;
    set.arlo = cond.scl_rise & master_i & data_bit_i & sda_drv_i & ~sda_s;
  end
  assign evf_set = set.berr | set.af;   // arbitration loss leaves the event flag alone

  i2c_mon_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set),
    .evf_set_i  (evf_set),
    .sr_read_i  (sr_read_i),
    .cr_write_i (cr_write_i),
    .start_req_i(start_req_i),
    .stop_req_i (stop_req_i),
    .flags_o    (flags),
    .evf_o      (evf),
    .af_hold_o  (af_hold_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) to_slave_q <= 1'b0;
    else         to_slave_q <= set.arlo;
  end

  assign berr_o         = flags.berr;
  assign af_o           = flags.af;
  assign arlo_o         = flags.arlo;
  assign evf_o          = evf;
  assign irq_o          = ite_i & (evf | flags.arlo);
  assign hold_release_o = |flags;
  assign to_slave_o     = to_slave_q;

  a_r2_berr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set.berr |=> berr_o && evf_o);
  a_r3_af_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set.af |=> af_o && evf_o && af_hold_o);
  a_r5_arlo_to_slave: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set.arlo |=> arlo_o && to_slave_o);
  a_r7_release_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set.berr || set.af || set.arlo) |=> hold_release_o);
  a_r1_cond_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cond.start, cond.stop}) <= 1);
endmodule

// File: tb/i2c_bus_err_mon_tb.sv
`timescale 1ns/1ps
module i2c_bus_err_mon_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, drv = 1'b1, master = 1'b0, byte_act = 1'b0;
  logic data_bit = 1'b0, ack_slot = 1'b0, ite = 1'b0;
  logic sr_rd = 1'b0, cr_wr = 1'b0, st_req = 1'b0, sp_req = 1'b0;
  logic berr, af, arlo, evf, irq, hold_rel, af_hold, to_slave;
  int n_chk = 0, n_fail = 0, pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_bus_err_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda), .sda_drv_i(drv),
    .master_i(master), .byte_active_i(byte_act), .data_bit_i(data_bit),
    .ack_slot_i(ack_slot), .ite_i(ite), .sr_read_i(sr_rd), .cr_write_i(cr_wr),
    .start_req_i(st_req), .stop_req_i(sp_req), .berr_o(berr), .af_o(af),
    .arlo_o(arlo), .evf_o(evf), .irq_o(irq), .hold_release_o(hold_rel),
    .af_hold_o(af_hold), .to_slave_o(to_slave)
  );

  always @(negedge clk) if (rst_n && to_slave) pulses++;

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(1); s = 1'b0; step(1);
  endtask

  // expected {berr, af, arlo} per scenario kind
  function automatic logic [2:0] exp_vec(int kind, bit p0, bit p1, bit p2);
    case (kind)
      0, 1:    return {p0, 1'b0, 1'b0};
      2:       return {1'b0, p0, 1'b0};
      3:       return {1'b0, 1'b0, p0 & p1 & ~p2};
      default: return 3'b000;
    endcase
  endfunction

  task automatic run_scn(int kind, bit p0, bit p1, bit p2);
    case (kind)
      0: begin // start
        scl = 0; step(4); sda = 1; step(4); byte_act = p0;
        scl = 1; step(4); sda = 0; step(4); scl = 0; step(4);
        byte_act = 0; sda = 1; step(4); scl = 1; step(4);
      end
      1: begin // stop
        scl = 0; step(4); sda = 0; step(4); byte_act = p0;
        scl = 1; step(4); sda = 1; step(4); scl = 0; step(4);
        byte_act = 0; scl = 1; step(4);
      end
      2: begin // ack slot, p0 = SDA high (no ack)
        scl = 0; step(4); sda = p0; ack_slot = 1; step(4);
        scl = 1; step(4); scl = 0; step(4); ack_slot = 0; sda = 1; step(4);
        scl = 1; step(4);
      end
      3: begin // arbitration: p0 master, p1 drive, p2 line
        scl = 0; step(4); sda = p2; master = p0; drv = p1; data_bit = 1; step(4);
        scl = 1; step(4); scl = 0; step(4); data_bit = 0; master = 0; drv = 1;
        sda = 1; step(4); scl = 1; step(4);
      end
      default: begin // SDA toggles with SCL low inside a byte
        scl = 0; step(4); byte_act = 1; sda = 0; step(4); sda = 1; step(4);
        byte_act = 0; scl = 1; step(4);
      end
    endcase
  endtask

  task automatic check_flags(string tag, logic [2:0] e, bit ie, int p_exp);
    logic ev;
    ev = e[2] | e[1];
    chk({tag, " R2"}, "berr", berr, e[2]);
    chk({tag, " R3"}, "af", af, e[1]);
    chk({tag, " R5"}, "arlo", arlo, e[0]);
    chk({tag, " R5"}, "evf", evf, ev);
    chk({tag, " R5"}, "to_slave pulses", pulses, p_exp);
    chk({tag, " R6"}, "irq", irq, ie & (ev | e[0]));
    chk({tag, " R7"}, "hold_release", hold_rel, |e);
    chk({tag, " R4"}, "af_hold", af_hold, e[1]);
  endtask

  task automatic clear_all();
    pulse(sr_rd); step(2); pulse(cr_wr); step(1);
  endtask

  initial begin
    void'($urandom(32'h5EED_0123));
    step(3);
    chk("R8 reset", "flags", {berr, af, arlo, evf, hold_rel, af_hold, to_slave}, 0);
    rst_n = 1; step(4);
    chk("R8 reset", "flags after release", {berr, af, arlo, evf, irq, hold_rel, af_hold}, 0);

    // R1: SDA activity under low SCL is not a condition
    run_scn(4, 0, 0, 0);
    chk("R1", "berr scl low", berr, 0);

    // R8: stickiness and two-step clear
    ite = 1; run_scn(0, 1, 0, 0);
    chk("R2", "berr on start in byte", berr, 1);
    chk("R6", "irq", irq, 1);
    step(20);
    chk("R8", "berr sticky", berr, 1);
    pulse(cr_wr); step(1);
    chk("R8", "write alone keeps berr", berr, 1);
    pulse(sr_rd); step(3);
    chk("R8", "read alone keeps berr", berr, 1);
    pulse(cr_wr); step(1);
    chk("R8", "read then write clears berr", berr, 0);
    chk("R8", "evf cleared", evf, 0);
    chk("R7", "hold_release low", hold_rel, 0);

    // R4: ack-failure freeze outlives the flag clear
    run_scn(2, 1, 0, 0);
    chk("R3", "af", af, 1);
    chk("R4", "af_hold", af_hold, 1);
    clear_all();
    chk("R4", "af_hold after clear", af_hold, 1);
    chk("R8", "af cleared", af, 0);
    pulse(st_req);
    chk("R4", "af_hold after start req", af_hold, 0);

    // R5: arbitration loss
    pulses = 0;
    run_scn(3, 1, 1, 0);
    chk("R5", "arlo", arlo, 1);
    chk("R5", "evf stays low", evf, 0);
    chk("R5", "single to_slave pulse", pulses, 1);
    clear_all();

    for (int it = 0; it < 60; it++) begin
      int kind;
      bit p0, p1, p2, ie;
      logic [2:0] e;
      kind = int'($urandom_range(0, 4));
      p0 = 1'($urandom); p1 = 1'($urandom); p2 = 1'($urandom); ie = 1'($urandom);
      ite = ie; pulses = 0;
      e = exp_vec(kind, p0, p1, p2);
      run_scn(kind, p0, p1, p2);
      check_flags($sformatf("rnd%0d k%0d", it, kind), e, ie, int'(e[0]));
      clear_all();
      chk("R8 rnd", "cleared", {berr, af, arlo, evf}, 0);
      pulse(sp_req);
      chk("R4 rnd", "af_hold after stop req", af_hold, 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule